// File: doc/BRIEF.md
# Fan Drive Triangle-Carrier PWM with Sleep/Run Hysteresis

This block makes the switching commands for the high-side PWM switch of a two-winding brushless fan drive. It also makes the commands for the synchronous low-side switch that carries the winding current while the high side is off. An 8-bit speed code is compared against an up/down counter that forms a triangle carrier between a floor code and a ceiling code. The high side conducts while the code lies above the carrier. The floor sits above zero, so every code at or below it gives no drive.

A run/sleep state machine with hysteresis on the same code decides whether the drive may switch at all. Drive is also blocked while an external thermal-fault flag is raised. The high side alone is also blocked until an external charge-pump-ready flag is set. A one-cycle strobe marks each carrier period so that other timers, such as a locked-rotor timer, can count PWM periods. The carrier rate is the clock rate divided by the carrier period. The clock is chosen so that this rate falls near 23 kHz.

Top module: `fan_pwm_core`

## Requirements
- R1: The carrier starts at 51 after reset. It steps by one each clock up to 235 and then down to 51, so its period is 368 clocks. `period_o` is high in exactly the cycles in which the carrier equals 51, including the first cycle after reset.
- R2: In run, with no fault and `cp_ready_i` high, the high side is requested when `ctrl_i` is greater than the carrier or `ctrl_i` is 235 or more. It is never requested for `ctrl_i` of 51 or less.
- R3: In steady run with no fault and `cp_ready_i` high, each carrier period has 2*(ctrl−51)−2 high cycles of `hs_pwm_o` and 470−2*ctrl high cycles of `ls_pwm_o`, for 52 ≤ ctrl ≤ 234. For ctrl ≥ 235, `hs_pwm_o` is high for all 368 cycles and `ls_pwm_o` for none.
- R4: From sleep, the block enters run one clock after it sees `ctrl_i` > 81. From run, it enters sleep one clock after it sees `ctrl_i` < 71. Codes from 71 to 81 keep the current state. `run_o` is high in run.
- R5: While in sleep, both `hs_pwm_o` and `ls_pwm_o` are low.
- R6: The low side is requested in run, with no fault, in every cycle in which the high side's carrier comparison is off. This holds even while `cp_ready_i` is low.
- R7: `hs_pwm_o` and `ls_pwm_o` are never high together. Each one rises only after the other has been low for at least DEAD_CYC (default 1) full clock cycles.
- R8: A clock edge that sees `therm_fault_i` high drives both outputs low. Drive resumes on its own once the flag clears.
- R9: A clock edge that sees `cp_ready_i` low drives `hs_pwm_o` low.
- R10: After reset the block is in sleep with both outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 8 | Speed control code (0 to 255 spans 0 to 2.5 control units) |
| therm_fault_i | input | 1 | Over-temperature flag; forces both switches off |
| cp_ready_i | input | 1 | Charge pump above its lock-out level; enables the high side |
| hs_pwm_o | output | 1 | High-side switch command |
| ls_pwm_o | output | 1 | Synchronous low-side switch command |
| run_o | output | 1 | High in run, low in sleep |
| period_o | output | 1 | One-cycle strobe per carrier period |

## Verification
A change on `ctrl_i` shows on `run_o` at the next clock edge. A switch command follows the carrier value, the code and the flags seen at an edge, and it appears at that same edge. When a switch must wait for the dead interval, its rise comes one edge later. `period_o` is decoded from the carrier register, so it is valid in the same cycle as the floor value. The bench's reference model advances at each rising edge and uses the inputs that were applied just after the previous edge. The outputs are compared at the following falling edge, and the per-period duty counts start from the sample that shows the strobe.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int CTRL_W_DEF   = 8;
  localparam int CAR_LO_DEF   = 51;   // 0.5 of 2.5 full scale
  localparam int CAR_HI_DEF   = 235;  // 2.3 of 2.5 full scale
  localparam int SLEEP_TH_DEF = 71;   // below: go to sleep
  localparam int START_TH_DEF = 81;   // above: leave sleep
  localparam int DEAD_DEF     = 1;

  typedef enum logic {
    ST_SLEEP = 1'b0,
    ST_RUN   = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/fan_pwm_carrier.sv
module fan_pwm_carrier #(
  parameter int W  = 8,
  parameter int LO = 51,
  parameter int HI = 235
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] car_o,
  output logic         floor_o
);
  localparam logic [W-1:0] LO_C = W'(LO);
  localparam logic [W-1:0] HI_C = W'(HI);

  logic [W-1:0] cnt_q;
  logic         up_q;
  logic [W-1:0] cnt_inc, cnt_dec;

  assign cnt_inc = cnt_q + W'(1);
  assign cnt_dec = cnt_q - W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LO_C;
      up_q  <= 1'b1;
    end else if (up_q) begin
      cnt_q <= cnt_inc;
      if (cnt_inc == HI_C) up_q <= 1'b0;
    end else begin
      cnt_q <= cnt_dec;
      if (cnt_dec == LO_C) up_q <= 1'b1;
    end
  end

  assign car_o   = cnt_q;
  assign floor_o = (cnt_q == LO_C);
endmodule

// File: rtl/fan_pwm_sleep.sv
module fan_pwm_sleep
  import fan_pwm_pkg::*;
#(
  parameter int W        = 8,
  parameter int SLEEP_TH = 71,
  parameter int START_TH = 81
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] ctrl_i,
  output logic         run_o
);
  localparam logic [W-1:0] SLP_C = W'(SLEEP_TH);
  localparam logic [W-1:0] STR_C = W'(START_TH);

  pwr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_SLEEP: if (ctrl_i > STR_C) st_d = ST_RUN;
      ST_RUN:   if (ctrl_i < SLP_C) st_d = ST_SLEEP;
      default:  st_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_SLEEP;
    else         st_q <= st_d;
  end

  assign run_o = (st_q == ST_RUN);
endmodule

// File: rtl/fan_pwm_dead_chan.sv
module fan_pwm_dead_chan #(
  parameter int DEAD = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic peer_on_i,
  input  logic peer_idle_ok_i,
  output logic on_o,
  output logic idle_ok_o
);
  localparam int CW = (DEAD < 1) ? 1 : $clog2(DEAD + 1);
  localparam logic [CW-1:0] DEAD_C = CW'(DEAD);

  logic          on_q, on_d;
  logic [CW-1:0] idle_q;

  // switch on only once the peer has been off long enough
  assign on_d = req_i && !peer_on_i && peer_idle_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= 1'b0;
      idle_q <= DEAD_C;
    end else begin
      on_q <= on_d;
      if (on_d)                 idle_q <= '0;
      else if (idle_q < DEAD_C) idle_q <= idle_q + CW'(1);
    end
  end

  assign on_o      = on_q;
  assign idle_ok_o = (idle_q >= DEAD_C);
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core
  import fan_pwm_pkg::*;
#(
  parameter int CTRL_W   = CTRL_W_DEF,
  parameter int CAR_LO   = CAR_LO_DEF,
  parameter int CAR_HI   = CAR_HI_DEF,
  parameter int SLEEP_TH = SLEEP_TH_DEF,
  parameter int START_TH = START_TH_DEF,
  parameter int DEAD_CYC = DEAD_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              therm_fault_i,
  input  logic              cp_ready_i,
  output logic              hs_pwm_o,
  output logic              ls_pwm_o,
  output logic              run_o,
  output logic              period_o
);
  localparam logic [CTRL_W-1:0] HI_C = CTRL_W'(CAR_HI);
  localparam int NCH = 2;  // 0: high side, 1: low side

  logic [CTRL_W-1:0] car;
  logic              run;
  logic              cmp_on;
  logic              drive_en;
  logic [NCH-1:0]    req, on, idle_ok;

  fan_pwm_carrier #(.W(CTRL_W), .LO(CAR_LO), .HI(CAR_HI)) u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .car_o  (car),
    .floor_o(period_o)
  );

  fan_pwm_sleep #(.W(CTRL_W), .SLEEP_TH(SLEEP_TH), .START_TH(START_TH)) u_slp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctrl_i(ctrl_i),
    .run_o (run)
  );

  // code at/above ceiling pins full duty
  assign cmp_on   = (ctrl_i >= HI_C) || (ctrl_i > car);
  assign drive_en = run && !therm_fault_i;
  assign req[0]   = drive_en && cp_ready_i && cmp_on;
  assign req[1]   = drive_en && !cmp_on;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    fan_pwm_dead_chan #(.DEAD(DEAD_CYC)) u_dc (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .req_i         (req[g]),
      .peer_on_i     (on[NCH-1-g]),
      .peer_idle_ok_i(idle_ok[NCH-1-g]),
      .on_o          (on[g]),
      .idle_ok_o     (idle_ok[g])
    );
  end

  assign hs_pwm_o = on[0];
  assign ls_pwm_o = on[1];
  assign run_o    = run;
endmodule

// File: rtl/fan_pwm_chk.sv
module fan_pwm_chk #(
  parameter int CTRL_W   = 8,
  parameter int SLEEP_TH = 71,
  parameter int START_TH = 81
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              therm_fault_i,
  input logic              cp_ready_i,
  input logic              hs_pwm_o,
  input logic              ls_pwm_o,
  input logic              run_o,
  input logic              period_o
);
  // R7
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_pwm_o && ls_pwm_o));
  // R7
  hs_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_pwm_o) |-> !$past(ls_pwm_o));
  // R7
  ls_dead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_pwm_o) |-> !$past(hs_pwm_o));
  // R5
  sleep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && !$past(run_o)) |-> (!hs_pwm_o && !ls_pwm_o));
  // R8
  fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(therm_fault_i) |-> (!hs_pwm_o && !ls_pwm_o));
  // R9
  cp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cp_ready_i) |-> !hs_pwm_o);
  // R4
  wake_th_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> ($past(ctrl_i) > CTRL_W'(START_TH)));
  // R4
  sleep_th_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_o) |-> ($past(ctrl_i) < CTRL_W'(SLEEP_TH)));
  // R1
  strobe_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_o |=> !period_o);
endmodule

bind fan_pwm_core fan_pwm_chk #(
  .CTRL_W  (CTRL_W),
  .SLEEP_TH(SLEEP_TH),
  .START_TH(START_TH)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_i       (ctrl_i),
  .therm_fault_i(therm_fault_i),
  .cp_ready_i   (cp_ready_i),
  .hs_pwm_o     (hs_pwm_o),
  .ls_pwm_o     (ls_pwm_o),
  .run_o        (run_o),
  .period_o     (period_o)
);

// File: tb/fan_pwm_core_tb.sv
`timescale 1ns/1ps
module fan_pwm_core_tb_top;
  localparam int LO = 51;
  localparam int HI = 235;
  localparam int PER = 2 * (HI - LO);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctrl = 8'd0;
  logic       fault = 1'b0;
  logic       cp = 1'b0;
  logic       hs, ls, run, per;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fan_pwm_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .therm_fault_i(fault),
    .cp_ready_i(cp), .hs_pwm_o(hs), .ls_pwm_o(ls), .run_o(run), .period_o(per)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int  m_k;
  bit  m_run, m_hs, m_ls;
  int  m_hs_low, m_ls_low;

  function automatic int carrier_at(int k);
    int p;
    p = k % PER;
    return (p <= PER / 2) ? LO + p : LO + PER - p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k = 0; m_run = 0; m_hs = 0; m_ls = 0;
      m_hs_low = 1000; m_ls_low = 1000;
    end else begin
      int  c;
      bit  on, en, rh, rl, nh, nl;
      c  = carrier_at(m_k);
      on = (int'(ctrl) >= HI) || (int'(ctrl) > c);
      en = m_run && !fault;
      rh = en && cp && on;
      rl = en && !on;
      nh = rh && !m_ls && (m_ls_low >= 1);
      nl = rl && !m_hs && (m_hs_low >= 1);
      m_hs_low = nh ? 0 : m_hs_low + 1;
      m_ls_low = nl ? 0 : m_ls_low + 1;
      m_hs = nh; m_ls = nl;
      if (m_run && int'(ctrl) < 71) m_run = 0;
      else if (!m_run && int'(ctrl) > 81) m_run = 1;
      m_k++;
    end
  end

  // cycle compare against the model (R2 R4 R6 R8 R9 R1)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R6 hs model", hs, m_hs);
      check("R6 ls model", ls, m_ls);
      check("R4 run model", run, m_run);
      check("R1 strobe model", per, (m_k % PER) == 0);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic measure(output int nh, output int nl, output int np);
    nh = 0; nl = 0; np = 0;
    do @(negedge clk); while (!per);
    for (int i = 0; i < PER; i++) begin
      if (i > 0) @(negedge clk);
      nh += hs; nl += ls; np += per;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int nh, nl, np;
    step(3);
    // R10 reset state
    check("R10 hs reset", hs, 0);
    check("R10 ls reset", ls, 0);
    check("R10 run reset", run, 0);
    check("R1 strobe at reset", per, 1);
    rst_n = 1'b1;
    step(1);
    check("R1 carrier leaves floor", per, 0);

    // wake and duty at code 200
    cp = 1'b1; ctrl = 8'd200;
    step(1);
    check("R4 wake after one edge", run, 1);
    step(2 * PER);
    measure(nh, nl, np);
    check("R3 hs count code200", nh, 2 * (200 - 51) - 2);
    check("R3 ls count code200", nl, 470 - 400);
    check("R1 one strobe per period", np, 1);

    ctrl = 8'd143; step(2 * PER);
    measure(nh, nl, np);
    check("R3 hs count code143", nh, 182);
    check("R3 ls count code143", nl, 184);

    ctrl = 8'd240; step(2 * PER);
    measure(nh, nl, np);
    check("R3 hs full code240", nh, PER);
    check("R3 ls none code240", nl, 0);

    ctrl = 8'd235; step(2 * PER);
    measure(nh, nl, np);
    check("R2 hs full at ceiling", nh, PER);

    // hysteresis band keeps run
    ctrl = 8'd75; step(2 * PER);
    check("R4 run held at 75", run, 1);
    measure(nh, nl, np);
    check("R3 hs count code75", nh, 46);
    ctrl = 8'd71; step(5);
    check("R4 run held at 71", run, 1);
    ctrl = 8'd70; step(1);
    check("R4 sleep below 71", run, 0);
    step(2);
    measure(nh, nl, np);
    check("R5 hs off in sleep", nh, 0);
    check("R5 ls off in sleep", nl, 0);
    ctrl = 8'd81; step(20);
    check("R4 sleep held at 81", run, 0);
    ctrl = 8'd82; step(1);
    check("R4 wake above 81", run, 1);

    // thermal fault
    ctrl = 8'd143; step(PER);
    fault = 1'b1; step(1);
    check("R8 hs off on fault", hs, 0);
    check("R8 ls off on fault", ls, 0);
    measure(nh, nl, np);
    check("R8 hs count fault", nh, 0);
    check("R8 ls count fault", nl, 0);
    fault = 1'b0; step(2 * PER);
    measure(nh, nl, np);
    check("R8 resume after fault", nh, 182);

    // charge pump not ready
    cp = 1'b0; step(2 * PER);
    measure(nh, nl, np);
    check("R9 hs blocked", nh, 0);
    check("R6 ls still switching", nl, 185);
    cp = 1'b1; step(2 * PER);
    measure(nh, nl, np);
    check("R9 hs back", nh, 182);

    // mid-period sleep: outputs drop within one edge after run falls
    ctrl = 8'd20; step(2);
    check("R5 hs off after sleep", hs, 0);
    check("R5 ls off after sleep", ls, 0);
    step(10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule